// File: doc/BRIEF.md
# Two-Symbol-Per-Clock TMDS Encoder

This block turns two 8-bit video bytes per clock into two 10-bit transition-minimised, DC-balanced TMDS symbols. It packs them into one 20-bit word for a 20:1 serializer that sits downstream. The work is split across a three-stage pipeline.

The first stage fetches a per-byte record from a 256-entry table. The record holds the transition-minimised intermediate word and its ones-minus-zeros balance. The second stage reads both records and the running disparity, decides whether each symbol is inverted, and carries the disparity through both symbols within that single cycle. The outcome is two 10-bit addresses into a 1024-entry symbol table. The third stage registers the two table outputs as the packed word.

During blanking (data enable low), both symbol slots carry one of four control codes, chosen by a 2-bit control input. Blanking also clears the running disparity. Both tables are computed at elaboration by constant functions.

Top module: `tmds_pair_enc`

## Requirements
- R1: While `rst_n` is low, `sym_pair` is all zeros and the running disparity is zero, so the first data pair after reset is encoded from a disparity of zero.
- R2: Inputs sampled at clock edge k appear on `sym_pair` after edge k+3. The symbol for `byte_lo` is in bits [9:0] (sent first) and the symbol for `byte_hi` is in bits [19:10].
- R3: For each byte, XNOR chaining is used when the byte has more than four ones, or exactly four ones with bit 0 equal to 0. Otherwise XOR chaining is used. Symbol bit 8 is 1 for XOR and 0 for XNOR.
- R4: When the running disparity is zero or the intermediate byte has four ones, bit 9 is the inverse of bit 8. In that case bits [7:0] are inverted exactly when bit 8 is 0.
- R5: In all other cases, bit 9 is 1 and bits [7:0] are inverted when the intermediate byte's imbalance has the same sign as the running disparity. After each data symbol, the running disparity changes by that symbol's ones-minus-zeros count and stays within -8..+8.
- R6: The symbol in bits [19:10] is encoded with the running disparity left by the symbol in bits [9:0] of the same word.
- R7: When `de` is low, both halves of the word carry the control code for `ctl`: 0 gives 10'h354, 1 gives 10'h0AB, 2 gives 10'h154, 3 gives 10'h2AB.
- R8: A cycle with `de` low resets the running disparity to zero, so the next data pair is encoded as if from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-pair clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| de | input | 1 | High for video data, low for blanking |
| ctl | input | 2 | Control code select during blanking |
| byte_lo | input | 8 | First byte of the pair |
| byte_hi | input | 8 | Second byte of the pair |
| sym_pair | output | 20 | Packed symbols, first symbol in [9:0] |

## Verification
A wrong running disparity does not show up in the word that caused it. It shows up as a wrong bit 9 and wrongly inverted low byte in a later symbol, often the high half of the same word or the next word three cycles on. A fault that only affects carrying the disparity from the low to the high symbol corrupts just bits [19:10]. Comparing every word against a reference that walks the symbols one at a time exposes either case within a few pairs of varied data. Blanking between bursts shows whether the disparity truly restarts at zero.

// File: rtl/tmds_pair_enc.sv
module tmds_pair_enc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        de,
  input  logic [1:0]  ctl,
  input  logic [7:0]  byte_lo,
  input  logic [7:0]  byte_hi,
  output logic [19:0] sym_pair
);

  localparam int BW  = 8;
  localparam int SW  = 10;
  localparam int RW  = 5;
  localparam int IW  = BW + 1 + 4;
  localparam int AW  = SW;
  localparam int PW  = RW + AW;

  function automatic logic [IW-1:0] minimise(input logic [BW-1:0] b);
    logic [BW:0] q;
    int n;
    int d;
    logic use_xnor;
    n = 0;
    for (int i = 0; i < BW; i++) n += int'(b[i]);
    use_xnor = (n > 4) || (n == 4 && !b[0]);
    q[0] = b[0];
    for (int i = 1; i < BW; i++) q[i] = use_xnor ? ~(q[i-1] ^ b[i]) : (q[i-1] ^ b[i]);
    q[BW] = !use_xnor;
    d = 0;
    for (int i = 0; i < BW; i++) d += q[i] ? 1 : -1;
    return {4'(d / 2), q};
  endfunction

  function automatic logic [SW-1:0] finish_sym(input logic [AW-1:0] a);
    return a[9] ? {1'b1, a[8], ~a[7:0]} : {1'b0, a[8], a[7:0]};
  endfunction

  function automatic logic [PW-1:0] steer(input logic [IW-1:0] e, input logic signed [RW-1:0] r);
    logic signed [RW-1:0] d2;
    logic signed [RW-1:0] nr;
    logic inv;
    d2 = {e[12], e[11:9], 1'b0};
    if (r == 0 || d2 == 0) begin
      inv = !e[8];
      nr  = e[8] ? r + d2 : r - d2;
    end else if (r[RW-1] == d2[RW-1]) begin
      inv = 1'b1;
      nr  = r - d2 + (e[8] ? 5'sd2 : 5'sd0);
    end else begin
      inv = 1'b0;
      nr  = r + d2 - (e[8] ? 5'sd0 : 5'sd2);
    end
    return {nr, inv, e[8:0]};
  endfunction

  function automatic logic [SW-1:0] blank_code(input logic [1:0] c);
    case (c)
      2'd0:    return 10'h354;
      2'd1:    return 10'h0AB;
      2'd2:    return 10'h154;
      default: return 10'h2AB;
    endcase
  endfunction

  logic [IW-1:0] info_rom [2**BW];
  logic [SW-1:0] sym_rom  [2**AW];

  for (genvar g = 0; g < 2**BW; g++) begin : g_info
    assign info_rom[g] = minimise(BW'(g));
  end
  for (genvar g = 0; g < 2**AW; g++) begin : g_sym
    assign sym_rom[g] = finish_sym(AW'(g));
  end

  logic [IW-1:0] s1_lo, s1_hi;
  logic          s1_de;
  logic [1:0]    s1_ctl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_lo  <= '0;
      s1_hi  <= '0;
      s1_de  <= 1'b0;
      s1_ctl <= 2'd0;
    end else begin
      s1_lo  <= info_rom[byte_lo];
      s1_hi  <= info_rom[byte_hi];
      s1_de  <= de;
      s1_ctl <= ctl;
    end
  end

  logic signed [RW-1:0] rd;
  logic [PW-1:0]        pick_lo, pick_hi;

  assign pick_lo = steer(s1_lo, rd);
  assign pick_hi = steer(s1_hi, signed'(pick_lo[PW-1:AW]));

  logic [AW-1:0] s2_lo, s2_hi;
  logic          s2_de;
  logic [1:0]    s2_ctl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_lo  <= '0;
      s2_hi  <= '0;
      s2_de  <= 1'b0;
      s2_ctl <= 2'd0;
      rd     <= '0;
    end else begin
      s2_lo  <= pick_lo[AW-1:0];
      s2_hi  <= pick_hi[AW-1:0];
      s2_de  <= s1_de;
      s2_ctl <= s1_ctl;
      rd     <= s1_de ? signed'(pick_hi[PW-1:AW]) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sym_pair <= '0;
    else if (s2_de) sym_pair <= {sym_rom[s2_hi], sym_rom[s2_lo]};
    else sym_pair <= {2{blank_code(s2_ctl)}};
  end

endmodule

module tmds_pair_enc_chk (
  input logic              clk,
  input logic              rst_n,
  input logic              de,
  input logic [1:0]        ctl,
  input logic [19:0]       sym_pair,
  input logic signed [4:0] rd
);

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  function automatic logic [9:0] want_ctl(input logic [1:0] c);
    case (c)
      2'd0:    return 10'h354;
      2'd1:    return 10'h0AB;
      2'd2:    return 10'h154;
      default: return 10'h2AB;
    endcase
  endfunction

  p_blank_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && !$past(de, 3)) |->
      (sym_pair[9:0] == want_ctl($past(ctl, 3)) && sym_pair[19:10] == sym_pair[9:0]));

  p_rd_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && !$past(de, 2)) |-> rd == 5'sd0);

  p_rd_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd >= -5'sd8 && rd <= 5'sd8);

  p_rd_even_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd[0] == 1'b0);

  p_rd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && $past(de, 2) && $past(rd) == 5'sd0 && $past(de, 3) == 1'b0 && age == 2'd3)
      |-> rd >= -5'sd8);

endmodule

bind tmds_pair_enc tmds_pair_enc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .de(de), .ctl(ctl), .sym_pair(sym_pair), .rd(rd)
);

// File: tb/sim_tmds_pair_enc.sv
module sim_tmds_pair_enc;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        de = 1'b0;
  logic [1:0]  ctl = 2'd0;
  logic [7:0]  byte_lo = 8'd0;
  logic [7:0]  byte_hi = 8'd0;
  logic [19:0] sym_pair;

  always #2 clk = ~clk;

  tmds_pair_enc u0 (
    .clk(clk), .rst_n(rst_n), .de(de), .ctl(ctl),
    .byte_lo(byte_lo), .byte_hi(byte_hi), .sym_pair(sym_pair)
  );

  typedef struct {
    logic [19:0] val;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  int   ref_rd = 0;
  logic drv_valid = 1'b0;
  logic [2:0] issued = 3'b000;
  bit   done = 1'b0;

  function automatic logic [9:0] ref_enc(input logic [7:0] b, inout int cnt);
    logic [8:0] qm;
    logic [9:0] o;
    int n1d, n1q, n0q;
    n1d = 0;
    for (int i = 0; i < 8; i++) if (b[i]) n1d++;
    qm[0] = b[0];
    if (n1d > 4 || (n1d == 4 && b[0] == 1'b0)) begin
      for (int i = 1; i < 8; i++) qm[i] = qm[i-1] ~^ b[i];
      qm[8] = 1'b0;
    end else begin
      for (int i = 1; i < 8; i++) qm[i] = qm[i-1] ^ b[i];
      qm[8] = 1'b1;
    end
    n1q = 0;
    for (int i = 0; i < 8; i++) if (qm[i]) n1q++;
    n0q = 8 - n1q;
    if (cnt == 0 || n1q == n0q) begin
      o = {~qm[8], qm[8], qm[8] ? qm[7:0] : ~qm[7:0]};
      if (qm[8]) cnt += n1q - n0q;
      else       cnt += n0q - n1q;
    end else if ((cnt > 0 && n1q > n0q) || (cnt < 0 && n0q > n1q)) begin
      o = {1'b1, qm[8], ~qm[7:0]};
      cnt += 2 * int'(qm[8]) + n0q - n1q;
    end else begin
      o = {1'b0, qm[8], qm[7:0]};
      cnt += -2 * int'(!qm[8]) + n1q - n0q;
    end
    return o;
  endfunction

  function automatic logic [9:0] ref_ctl(input logic [1:0] c);
    case (c)
      2'd0:    return 10'h354;
      2'd1:    return 10'h0AB;
      2'd2:    return 10'h154;
      default: return 10'h2AB;
    endcase
  endfunction

  task automatic send(input logic d, input logic [1:0] c, input logic [7:0] a,
                      input logic [7:0] b, input string tag);
    exp_t e;
    logic [9:0] lo, hi;
    @(negedge clk);
    de = d; ctl = c; byte_lo = a; byte_hi = b;
    if (d) begin
      lo = ref_enc(a, ref_rd);
      hi = ref_enc(b, ref_rd);
      e.val = {hi, lo};
    end else begin
      ref_rd = 0;
      e.val = {2{ref_ctl(c)}};
    end
    e.tag = tag;
    exp_q.push_back(e);
    drv_valid = 1'b1;
  endtask

  always @(posedge clk) issued <= {issued[1:0], drv_valid};

  always @(negedge clk) begin
    if (issued[2] && !done) begin
      exp_t e;
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R2 output word %h with no expected item (expected none)", sym_pair);
      end else begin
        e = exp_q.pop_front();
        if (sym_pair !== e.val) begin
          n_bad++;
          $display("FAIL %s actual %h expected %h", e.tag, sym_pair, e.val);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if (sym_pair !== 20'h0) begin
      n_bad++;
      $display("FAIL R1 reset word actual %h expected %h", sym_pair, 20'h0);
    end
    rst_n = 1'b1;

    // R1: first data pair after reset starts from zero disparity
    send(1'b1, 2'd0, 8'h00, 8'h00, "R1");
    send(1'b1, 2'd0, 8'h00, 8'h00, "R5");
    // R7: every control code
    for (int c = 0; c < 4; c++) send(1'b0, 2'(c), 8'h00, 8'h00, "R7");
    // R8: disparity restart after blanking
    send(1'b1, 2'd0, 8'h00, 8'h00, "R8");
    send(1'b1, 2'd0, 8'hFF, 8'hFF, "R5");
    send(1'b0, 2'd2, 8'hAA, 8'h55, "R7");
    send(1'b1, 2'd0, 8'hFF, 8'h00, "R8");
    // R3: four-ones boundary with bit 0 low and high
    send(1'b1, 2'd0, 8'h0F, 8'h1E, "R3");
    send(1'b1, 2'd0, 8'hF0, 8'h3C, "R3");
    send(1'b1, 2'd0, 8'h1F, 8'h10, "R3");
    // R4: balanced intermediate words and zero disparity
    send(1'b0, 2'd1, 8'h00, 8'h00, "R7");
    send(1'b1, 2'd0, 8'h55, 8'hAA, "R4");
    send(1'b1, 2'd0, 8'h33, 8'hCC, "R4");
    // R6: pairs that push the disparity hard within one word
    for (int i = 0; i < 64; i++) send(1'b1, 2'd0, 8'(i * 4), 8'(255 - i * 4), "R6");
    for (int i = 0; i < 32; i++) send(1'b1, 2'd0, 8'h01, 8'h01, "R6");
    // R2/R5: long random stream with occasional blanking
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 49) == 0)
        send(1'b0, 2'($urandom_range(0, 3)), 8'h00, 8'h00, "R8");
      else
        send(1'b1, 2'd0, 8'($urandom), 8'($urandom), "R2");
    end
    @(negedge clk);
    drv_valid = 1'b0;
    repeat (5) @(negedge clk);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R2 pending items actual %0d expected 0", exp_q.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

endmodule